// File: doc/BRIEF.md
# Branch and Subroutine-Call Sequencer

This block carries out the control-transfer instructions of a 16-bit processor with a 24-bit word address space. It owns the program counter and the stack pointer. It accepts one decoded control-transfer command at a time and resolves conditional jumps against the carry, negative and zero flags. It also performs the three instructions that touch the stack: subroutine call, return, and push of the program counter. The stack lives in the processor's ordinary data memory and shares its pointer with data pushes and pops, so return addresses sit among data words. The memory itself is outside the block and is reached through a request/response port.

The condition code has two bit fields. The two low bits select the always-true condition, carry, negative or zero. The top bit inverts the selected condition. Inverting "always" would give a jump that is never taken. That encoding is decoded as a subroutine call instead. A call pushes the return address and loads the target as one uninterruptible operation. The program counter is only updated once both stack words have been accepted.

Both interfaces use valid/ready back-pressure. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low while a stack sequence is in progress. A memory request transfers on an edge where `mem_valid` and `mem_ready` are both high. Until that edge the request holds its address, direction and write data unchanged. Read data comes back in a later cycle, flagged by a one-cycle `mem_rvalid` pulse. Only one read is ever outstanding.

Top module: `branch_seq`

## Requirements
- R1: After reset `pc` equals RESET_PC (default 0x000100), `sp` equals RESET_SP (default 0x000000), `cmd_ready` is 1 and `mem_valid` is 0.
- R2: For `cmd_op`=0 (jump), `cmd_cond[1:0]` selects the condition: 0 always, 1 carry, 2 negative, 3 zero. `cmd_cond[2]`=1 inverts the condition. A taken jump loads the target into `pc`.
- R3: A jump that is not taken advances `pc` by 1 for the short form (`cmd_global`=0) and by 2 for the global form. The stack is not touched. `pc` wraps modulo 2^24.
- R4: The short-form target keeps `pc[23:8]` and replaces `pc[7:0]` with `cmd_target[7:0]`. The global-form target is all 24 bits of `cmd_target`.
- R5: `cmd_op`=0 with `cmd_cond`=3'b100 is a subroutine call. It pushes the return address (`pc`+1 short, `pc`+2 global) and then loads the target. `pc` keeps its old value until the second push word is accepted.
- R6: A 24-bit value is pushed as two words. The first word is the upper 8 bits, zero-extended, written at `sp`-1. The second word is the low 16 bits, written at the new `sp`-1. `sp` decrements by one on each accepted write.
- R7: Return (`cmd_op`=1) reads the low word at `sp` and then the high word at the new `sp`. `sp` increments by one on each accepted read. `pc` becomes {high[7:0], low} when the second read data arrives.
- R8: Push-PC (`cmd_op`=2) pushes `pc`+1 in the word order of R6 and sets `pc` to `pc`+1.
- R9: While `mem_valid` is high and `mem_ready` is low, the request stays valid and `mem_addr`, `mem_write` and `mem_wdata` stay unchanged.
- R10: `cmd_ready` is low, and no command is taken, from the edge that accepts a call, return or push-PC until that sequence completes. While `cmd_ready` is high, `mem_valid` is low.
- R11: The flags and command fields are used only at the accepting edge. Changes to them afterwards do not affect the result.
- R12: `cmd_op`=3 is reserved. It advances `pc` by 1 and leaves `sp` and memory untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 0 jump/call, 1 return, 2 push PC, 3 reserved |
| cmd_cond | input | 3 | Condition select [1:0], invert [2] |
| cmd_global | input | 1 | Two-word form with 24-bit target |
| cmd_target | input | ADDR_W | Jump target (low PAGE_W bits in short form) |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| mem_valid | output | 1 | Stack memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Stack word address |
| mem_wdata | output | WORD_W | Word to write |
| mem_rdata | input | WORD_W | Read data |
| mem_rvalid | input | 1 | Read data valid pulse |
| pc | output | ADDR_W | Program counter |
| sp | output | ADDR_W | Stack pointer |

## Verification
Suppose the sequencer's phase register or stack pointer went wrong. At the next memory handshake the address would no longer match the one computed from the pointer, or the two pushed words would come out swapped. After a return, `pc` would land somewhere other than just past the call. The bench compares every memory handshake against a reference model as soon as it happens, so a bad pointer or phase is caught within the cycle of the first stack access. A bad condition decode or target merge shows up one clock after the command edge, when `pc` is compared with the model.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [1:0] {
    OP_JUMP   = 2'd0,
    OP_RET    = 2'd1,
    OP_PUSHPC = 2'd2,
    OP_RSVD   = 2'd3
  } bsq_op_e;

  // condition field: [1:0] selects the flag, [2] inverts it
  typedef enum logic [1:0] {
    SEL_ALWAYS = 2'd0,
    SEL_CARRY  = 2'd1,
    SEL_NEG    = 2'd2,
    SEL_ZERO   = 2'd3
  } bsq_sel_e;

  // the inverted "always" code, which would never branch, means call
  localparam logic [2:0] COND_CALL = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO_REQ,
    ST_POP_LO_WAIT,
    ST_POP_HI_REQ,
    ST_POP_HI_WAIT
  } bsq_state_e;

endpackage

// File: rtl/bsq_cond.sv
module bsq_cond
  import bsq_pkg::*;
(
  input  logic [2:0] cond,
  input  logic       flag_c,
  input  logic       flag_n,
  input  logic       flag_z,
  output logic       taken,
  output logic       is_call
);

  logic raw;

  always_comb begin
    unique case (bsq_sel_e'(cond[1:0]))
      SEL_ALWAYS: raw = 1'b1;
      SEL_CARRY:  raw = flag_c;
      SEL_NEG:    raw = flag_n;
      SEL_ZERO:   raw = flag_z;
      default:    raw = 1'b0;
    endcase
  end

  assign taken   = raw ^ cond[2];
  assign is_call = (cond == COND_CALL);

endmodule

// File: rtl/bsq_target.sv
module bsq_target #(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  input  logic              is_global,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] dest
);

  logic [ADDR_W-1:0] len;

  // instruction length is one word, or two for the global form
  assign len    = {{(ADDR_W-2){1'b0}}, is_global, ~is_global};
  assign seq_pc = pc + len;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flat
      assign dest = target;
    end else begin : g_paged
      assign dest = is_global ? target
                              : {pc[ADDR_W-1:PAGE_W], target[PAGE_W-1:0]};
    end
  endgenerate

endmodule

// File: rtl/bsq_stack_port.sv
module bsq_stack_port #(
  parameter int              ADDR_W   = 24,
  parameter int              WORD_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_SP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_write,
  input  logic              fire,
  input  logic              hi_phase,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);

  localparam int HI_W = ADDR_W - WORD_W;
  localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= RESET_SP;
    end else if (fire) begin
      sp_q <= req_write ? sp_q - STEP : sp_q + STEP;
    end
  end

  assign sp       = sp_q;
  assign mem_addr = req_write ? sp_q - STEP : sp_q;

  // upper part of the return address first, zero-extended to a word
  assign mem_wdata = hi_phase ? {{(WORD_W-HI_W){1'b0}}, ret_addr[ADDR_W-1:WORD_W]}
                              : ret_addr[WORD_W-1:0];

endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import bsq_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                WORD_W   = 16,
  parameter int                PAGE_W   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = 24'h000100,
  parameter logic [ADDR_W-1:0] RESET_SP = 24'h000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [2:0]        cmd_cond,
  input  logic              cmd_global,
  input  logic [ADDR_W-1:0] cmd_target,
  input  logic              flag_c,
  input  logic              flag_n,
  input  logic              flag_z,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp
);

  localparam int HI_W = ADDR_W - WORD_W;

  bsq_state_e        state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] ret_q;
  logic [ADDR_W-1:0] dest_q;
  logic [WORD_W-1:0] lo_q;

  bsq_op_e           op;
  logic              accept;
  logic              taken;
  logic              is_call;
  logic              long_form;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] dest;
  logic              fire;

  assign op        = bsq_op_e'(cmd_op);
  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign long_form = cmd_global && (op == OP_JUMP);

  bsq_cond u_cond (
    .cond    (cmd_cond),
    .flag_c  (flag_c),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .taken   (taken),
    .is_call (is_call)
  );

  bsq_target #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_target (
    .pc        (pc_q),
    .target    (cmd_target),
    .is_global (long_form),
    .seq_pc    (seq_pc),
    .dest      (dest)
  );

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    unique case (state_q)
      ST_PUSH_HI, ST_PUSH_LO: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
      end
      ST_POP_LO_REQ, ST_POP_HI_REQ: begin
        mem_valid = 1'b1;
      end
      default: ;
    endcase
  end

  assign fire = mem_valid && mem_ready;

  bsq_stack_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RESET_SP(RESET_SP)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_write (mem_write),
    .fire      (fire),
    .hi_phase  (state_q == ST_PUSH_HI),
    .ret_addr  (ret_q),
    .sp        (sp),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= RESET_PC;
      ret_q   <= '0;
      dest_q  <= '0;
      lo_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            unique case (op)
              OP_JUMP: begin
                if (is_call) begin
                  ret_q   <= seq_pc;
                  dest_q  <= dest;
                  state_q <= ST_PUSH_HI;
                end else begin
                  pc_q <= taken ? dest : seq_pc;
                end
              end
              OP_RET:    state_q <= ST_POP_LO_REQ;
              OP_PUSHPC: begin
                ret_q   <= seq_pc;
                dest_q  <= seq_pc;
                state_q <= ST_PUSH_HI;
              end
              default:   pc_q <= seq_pc;
            endcase
          end
        end
        ST_PUSH_HI: if (fire) state_q <= ST_PUSH_LO;
        ST_PUSH_LO: begin
          if (fire) begin
            pc_q    <= dest_q;
            state_q <= ST_IDLE;
          end
        end
        ST_POP_LO_REQ: if (fire) state_q <= ST_POP_LO_WAIT;
        ST_POP_LO_WAIT: begin
          if (mem_rvalid) begin
            lo_q    <= mem_rdata;
            state_q <= ST_POP_HI_REQ;
          end
        end
        ST_POP_HI_REQ: if (fire) state_q <= ST_POP_HI_WAIT;
        ST_POP_HI_WAIT: begin
          if (mem_rvalid) begin
            pc_q    <= {mem_rdata[HI_W-1:0], lo_q};
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pc = pc_q;

endmodule

// File: rtl/bsq_check.sv
module bsq_check #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_rvalid,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] sp
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_valid); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R9

  AST_PUSH_BELOW_SP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> mem_addr == sp - ONE); // R6

  AST_POP_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write |-> mem_addr == sp); // R7

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && mem_ready) |=> sp == $past(sp)); // R6

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_write |=> sp == $past(sp) - ONE); // R6

  AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_write |=> sp == $past(sp) + ONE); // R7

  AST_PC_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready && !mem_rvalid && !(mem_valid && mem_ready && mem_write) |=> pc == $past(pc)); // R5

endmodule

bind branch_seq bsq_check #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bsq_check (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_write  (mem_write),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_rvalid (mem_rvalid),
  .pc         (pc),
  .sp         (sp)
);

// File: tb/branch_seq_test.sv
module branch_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] RST_PC = 24'h000100;
  localparam logic [23:0] RST_SP = 24'h000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [2:0]  cmd_cond = '0;
  logic        cmd_global = 1'b0;
  logic [23:0] cmd_target = '0;
  logic        flag_c = 1'b0, flag_n = 1'b0, flag_z = 1'b0;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic [23:0] pc, sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_cond(cmd_cond), .cmd_global(cmd_global),
    .cmd_target(cmd_target), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .pc(pc), .sp(sp)
  );

  typedef struct { bit wr; logic [23:0] addr; logic [15:0] data; string req; } xact_t;

  int          errors = 0;
  int          checks = 0;
  logic [23:0] m_pc = RST_PC;
  logic [23:0] m_sp = RST_SP;
  bit          idle_chk = 1'b0;
  xact_t       exp_q[$];
  logic [15:0] mem_img [logic [23:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_img(input logic [23:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 16'h0000;
  endfunction

  // memory responder with varying stalls and read latency
  int          stall = 0;
  int          seed = 0;
  bit          pend_rd = 1'b0;
  int          rd_delay = 0;
  logic [23:0] pend_addr = '0;

  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_ready  = 1'b0;
      if (pend_rd) begin
        if (rd_delay == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd_img(pend_addr);
          pend_rd    = 1'b0;
        end else begin
          rd_delay--;
        end
      end else if (rst_n && mem_valid) begin
        if (stall > 0) begin
          stall--;
        end else begin
          mem_ready = 1'b1;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R10", "unexpected memory request", {8'h0, mem_addr}, 32'h0);
          end else begin
            xact_t e;
            e = exp_q.pop_front();
            chk(mem_write == e.wr, e.req, "request direction", {31'h0, mem_write}, {31'h0, e.wr});
            chk(mem_addr == e.addr, e.req, "request address", {8'h0, mem_addr}, {8'h0, e.addr});
            if (e.wr) chk(mem_wdata == e.data, e.req, "pushed word", {16'h0, mem_wdata}, {16'h0, e.data});
          end
          if (mem_write) begin
            mem_img[mem_addr] = mem_wdata;
          end else begin
            pend_rd   = 1'b1;
            pend_addr = mem_addr;
            rd_delay  = seed % 3;
          end
          seed++;
          stall = seed % 3;
        end
      end
    end
  end

  // per-clock comparison of architectural state while idle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && idle_chk) begin
        chk(pc == m_pc, "R11", "idle pc", {8'h0, pc}, {8'h0, m_pc});
        chk(sp == m_sp, "R11", "idle sp", {8'h0, sp}, {8'h0, m_sp});
      end
    end
  end

  task automatic push_exp(input logic [23:0] r, input string req);
    exp_q.push_back('{1'b1, m_sp - 24'd1, {8'h00, r[23:16]}, req});
    exp_q.push_back('{1'b1, m_sp - 24'd2, r[15:0], req});
  endtask

  task automatic run(input logic [1:0] op, input logic [2:0] cond, input bit glob,
                     input logic [23:0] tgt, input bit c, input bit n, input bit z,
                     input string req);
    logic [23:0] nxt, dst, new_pc, new_sp;
    logic [15:0] lo, hi;
    bit          tk, raw, busy;
    int          guard;
    nxt = m_pc + ((glob && op == 2'd0) ? 24'd2 : 24'd1);
    dst = glob ? tgt : {m_pc[23:8], tgt[7:0]};
    new_sp = m_sp;
    busy = 1'b0;
    case (cond[1:0])
      2'd0: raw = 1'b1;
      2'd1: raw = c;
      2'd2: raw = n;
      default: raw = z;
    endcase
    tk = raw ^ cond[2];
    case (op)
      2'd0: begin
        if (cond == 3'b100) begin
          push_exp(nxt, "R5");
          new_pc = dst; new_sp = m_sp - 24'd2; busy = 1'b1;
        end else begin
          new_pc = tk ? dst : nxt;
        end
      end
      2'd1: begin
        lo = rd_img(m_sp);
        hi = rd_img(m_sp + 24'd1);
        exp_q.push_back('{1'b0, m_sp, 16'h0, "R7"});
        exp_q.push_back('{1'b0, m_sp + 24'd1, 16'h0, "R7"});
        new_pc = {hi[7:0], lo}; new_sp = m_sp + 24'd2; busy = 1'b1;
      end
      2'd2: begin
        push_exp(nxt, "R8");
        new_pc = nxt; new_sp = m_sp - 24'd2; busy = 1'b1;
      end
      default: new_pc = nxt;
    endcase

    idle_chk = 1'b0;
    @(negedge clk);
    cmd_op = op; cmd_cond = cond; cmd_global = glob; cmd_target = tgt;
    flag_c = c; flag_n = n; flag_z = z;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    // scramble inputs after acceptance; they must not matter (R11)
    cmd_op = ~op; cmd_cond = ~cond; cmd_global = ~glob; cmd_target = ~tgt;
    flag_c = ~c; flag_n = ~n; flag_z = ~z;
    if (busy) begin
      chk(cmd_ready == 1'b0, "R10", "ready during sequence", {31'h0, cmd_ready}, 32'h0);
      chk(pc == m_pc, "R5", "pc held during sequence", {8'h0, pc}, {8'h0, m_pc});
    end
    guard = 0;
    while (!cmd_ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    m_pc = new_pc;
    m_sp = new_sp;
    chk(pc == m_pc, req, "pc after command", {8'h0, pc}, {8'h0, m_pc});
    chk(sp == m_sp, req, "sp after command", {8'h0, sp}, {8'h0, m_sp});
    chk(exp_q.size() == 0, req, "memory requests left", exp_q.size(), 32'h0);
    exp_q.delete();
    idle_chk = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc == RST_PC, "R1", "reset pc", {8'h0, pc}, {8'h0, RST_PC});
    chk(sp == RST_SP, "R1", "reset sp", {8'h0, sp}, {8'h0, RST_SP});
    chk(cmd_ready == 1'b1, "R1", "reset ready", {31'h0, cmd_ready}, 32'h1);
    chk(mem_valid == 1'b0, "R1", "reset request", {31'h0, mem_valid}, 32'h0);
    idle_chk = 1'b1;

    // R4 short and global targets, R2 unconditional
    run(2'd0, 3'b000, 1'b0, 24'hABCD37, 0, 0, 0, "R4");
    run(2'd0, 3'b000, 1'b1, 24'h123456, 0, 0, 0, "R4");
    // R2 / R3 each condition and complement, both flag values, both forms
    for (int sel = 1; sel < 4; sel++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int f = 0; f < 2; f++) begin
          for (int g = 0; g < 2; g++) begin
            run(2'd0, {inv[0], sel[1:0]}, g[0], 24'h00F000 + 24'(sel * 16 + f),
                (sel == 1) ? f[0] : ~f[0], (sel == 2) ? f[0] : ~f[0],
                (sel == 3) ? f[0] : ~f[0], (f[0] ^ inv[0]) ? "R2" : "R3");
          end
        end
      end
    end
    // R5 / R6 global call, stack wraps below zero
    run(2'd0, 3'b100, 1'b1, 24'h7A0010, 0, 0, 0, "R5");
    // R5 short call, R8 push pc, R7 returns
    run(2'd0, 3'b100, 1'b0, 24'h000044, 1, 1, 1, "R6");
    run(2'd2, 3'b000, 1'b0, 24'h000000, 0, 0, 0, "R8");
    run(2'd1, 3'b000, 1'b0, 24'h000000, 0, 0, 0, "R7");
    run(2'd1, 3'b000, 1'b0, 24'h000000, 0, 0, 0, "R7");
    run(2'd1, 3'b000, 1'b0, 24'h000000, 0, 0, 0, "R7");
    // R12 reserved op
    run(2'd3, 3'b101, 1'b1, 24'h555555, 1, 0, 1, "R12");
    // R3 wrap of pc at the top of the space
    run(2'd0, 3'b000, 1'b1, 24'hFFFFFF, 0, 0, 0, "R4");
    run(2'd0, 3'b001, 1'b1, 24'h000000, 0, 0, 0, "R3");
    // R9 back-pressure is exercised by stalls in the responder on these
    run(2'd2, 3'b000, 1'b0, 24'h000000, 0, 0, 0, "R9");
    run(2'd1, 3'b000, 1'b0, 24'h000000, 0, 0, 0, "R9");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule